// File: doc/BRIEF.md
# Pad Function Routing Fabric

This block sits between a chip's peripheral function wires and its I/O pads and connects them many-to-many under software control. Each pad owns a small select register. Its value picks one of the pad's function slots. That one setting routes the chosen function's output value and its direction control to the pad, and it also offers the pad's input level to that function. A function can appear on several pads at once, and one pad can feed a function input while it also drives the pad.

When more than one pad selects the same function input, a priority stage lets the lowest-numbered pad win. Two pad levels can therefore never fight on one function input. Bus-type functions, such as bidirectional data lines and the GPIO function, drive the pad direction themselves. Output-only functions always drive their pad. Input-only functions and empty slots leave the pad undriven. The select registers are written and read through a small word-addressed port.

Top module: `pinmux_fabric`

## Requirements
- R1: After reset every select register reads 0. A write with `cfg_we` high stores `cfg_wdata` into the register at `cfg_addr` on the next rising clock edge. `cfg_rdata` shows the register at `cfg_addr` combinationally.
- R2: A write to an address at or above NUM_PADS changes no register. A read at such an address returns 0.
- R3: Slot s of pad p connects to function (p + s) mod (NUM_FN + 1). The value NUM_FN means the slot is empty.
- R4: `pad_out[p]` equals `fn_out[f]` of the selected function f when f has an output (default output mask 4'b1011, bit f). It is 0 for an empty slot or an input-only function.
- R5: `pad_oe[p]` equals `fn_oe[f]` for a bus-type function (default bus mask 4'b1001). It is 1 for a non-bus function with an output and 0 for an empty slot or an input-only function.
- R6: `fn_in[f]` of an input-capable function (default input mask 4'b1101) equals `pad_in` of the lowest-indexed pad that selects f. It is 0 when no pad selects f.
- R7: An output-only function's `fn_in` bit stays 0, whatever the pads select and whatever their input levels are.
- R8: One function may be selected on several pads at once. Each of those pads carries that function's output and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register word address (pad index) |
| cfg_wdata | input | SEL_W | Select value to write |
| cfg_rdata | output | SEL_W | Select value at cfg_addr |
| fn_out | input | NUM_FN | Output value of each function |
| fn_oe | input | NUM_FN | Direction request of each function (bus-type only) |
| fn_in | output | NUM_FN | Resolved input value of each function |
| pad_in | input | NUM_PADS | Level seen at each pad |
| pad_out | output | NUM_PADS | Value driven to each pad |
| pad_oe | output | NUM_PADS | Output enable of each pad |

## Verification
The assertions assume `cfg_addr` and `cfg_wdata` are never unknown while `cfg_we` is high. They also assume that the function and pad inputs are settled when the clock samples them, because routing is purely combinational. The bench changes every input half a cycle away from the rising edge and keeps all values defined. It writes select registers only through the port, with a full cycle per write. It then walks all 256 combinations of the four 2-bit selects with two input patterns each.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

  // Function wired to a given slot of a given pad; nfn means no function.
  function automatic int unsigned slot_target(int unsigned pad, int unsigned slot,
                                              int unsigned nfn);
    return (pad + slot) % (nfn + 1);
  endfunction

endpackage

// File: rtl/pinmux_sel_regs.sv
module pinmux_sel_regs #(
  parameter int NUM_PADS = 4,
  parameter int SEL_W    = 2,
  parameter int ADDR_W   = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [SEL_W-1:0]          wdata,
  output logic [SEL_W-1:0]          rdata,
  output logic [NUM_PADS*SEL_W-1:0] sel_flat
);

  logic [SEL_W-1:0] sel_q [NUM_PADS];
  logic [NUM_PADS-1:0] wr_hit;

  always_comb begin
    for (int k = 0; k < NUM_PADS; k++) begin
      wr_hit[k] = we && (addr == ADDR_W'(k));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_PADS; k++) sel_q[k] <= '0;
    end else begin
      for (int k = 0; k < NUM_PADS; k++) begin
        if (wr_hit[k]) sel_q[k] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NUM_PADS; k++) begin
      if (addr == ADDR_W'(k)) rdata = sel_q[k];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_PADS; g++) begin : g_pad
      assign sel_flat[g*SEL_W +: SEL_W] = sel_q[g];

      AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit[g] |=> sel_q[g] == $past(wdata)); // R1
      AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == ADDR_W'(g)) |=> $stable(sel_q[g])); // R2
    end
  endgenerate

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit)); // R1

endmodule

// File: rtl/pinmux_pad_route.sv
module pinmux_pad_route
  import pinmux_pkg::*;
#(
  parameter int PAD_IDX = 0,
  parameter int NUM_FN  = 4,
  parameter int SEL_W   = 2,
  parameter logic [NUM_FN-1:0] OUT_MASK = 4'b1011,
  parameter logic [NUM_FN-1:0] BUS_MASK = 4'b1001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel,
  input  logic [NUM_FN-1:0] fn_out,
  input  logic [NUM_FN-1:0] fn_oe,
  output logic              pad_out,
  output logic              pad_oe,
  output logic [NUM_FN-1:0] sel_hit
);

  int unsigned tgt;
  logic        slot_live;

  always_comb begin
    tgt       = slot_target(PAD_IDX, 32'(sel), NUM_FN);
    slot_live = 1'b0;
    sel_hit   = '0;
    pad_out   = 1'b0;
    pad_oe    = 1'b0;
    for (int unsigned f = 0; f < NUM_FN; f++) begin
      if (tgt == f) begin
        slot_live  = 1'b1;
        sel_hit[f] = 1'b1;
        if (OUT_MASK[f]) begin
          pad_out = fn_out[f];
          pad_oe  = BUS_MASK[f] ? fn_oe[f] : 1'b1;
        end
      end
    end
  end

  AST_EMPTY_SLOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_live |-> (!pad_out && !pad_oe)); // R4
  AST_SINGLE_FN: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_hit)); // R3
  AST_NO_DRIVE_WITHOUT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_hit & OUT_MASK) == '0) |-> !pad_oe); // R5

endmodule

// File: rtl/pinmux_fn_prio.sv
module pinmux_fn_prio #(
  parameter int NUM_PADS = 4,
  parameter bit HAS_IN   = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] hit_col,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] win,
  output logic                fn_in
);

  always_comb begin
    if (HAS_IN) win = hit_col & (~hit_col + NUM_PADS'(1));
    else        win = '0;
    fn_in = |(win & pad_in);
  end

  AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win)); // R6
  AST_WINNER_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (win & ~hit_col) == '0); // R6
  AST_IDLE_INPUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_col == '0) |-> !fn_in); // R6
  AST_OUTPUT_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_IN |-> !fn_in); // R7

endmodule

// File: rtl/pinmux_fabric.sv
module pinmux_fabric #(
  parameter int NUM_PADS = 4,
  parameter int NUM_FN   = 4,
  parameter int SEL_W    = 2,
  parameter int ADDR_W   = 3,
  parameter logic [NUM_FN-1:0] OUT_MASK = 4'b1011,
  parameter logic [NUM_FN-1:0] IN_MASK  = 4'b1101,
  parameter logic [NUM_FN-1:0] BUS_MASK = 4'b1001
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [SEL_W-1:0]    cfg_wdata,
  output logic [SEL_W-1:0]    cfg_rdata,
  input  logic [NUM_FN-1:0]   fn_out,
  input  logic [NUM_FN-1:0]   fn_oe,
  output logic [NUM_FN-1:0]   fn_in,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe
);

  logic [NUM_PADS*SEL_W-1:0] sel_flat;
  logic [NUM_FN-1:0]         pad_hit [NUM_PADS];
  logic [NUM_PADS-1:0]       fn_hit  [NUM_FN];
  logic [NUM_PADS-1:0]       fn_win  [NUM_FN];

  pinmux_sel_regs #(
    .NUM_PADS(NUM_PADS), .SEL_W(SEL_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .sel_flat(sel_flat)
  );

  genvar p, f;
  generate
    for (p = 0; p < NUM_PADS; p++) begin : g_pad
      pinmux_pad_route #(
        .PAD_IDX(p), .NUM_FN(NUM_FN), .SEL_W(SEL_W),
        .OUT_MASK(OUT_MASK), .BUS_MASK(BUS_MASK)
      ) u_route (
        .clk(clk), .rst_n(rst_n), .sel(sel_flat[p*SEL_W +: SEL_W]),
        .fn_out(fn_out), .fn_oe(fn_oe),
        .pad_out(pad_out[p]), .pad_oe(pad_oe[p]), .sel_hit(pad_hit[p])
      );
    end

    for (f = 0; f < NUM_FN; f++) begin : g_fn
      for (p = 0; p < NUM_PADS; p++) begin : g_col
        assign fn_hit[f][p] = pad_hit[p][f];
      end

      pinmux_fn_prio #(
        .NUM_PADS(NUM_PADS), .HAS_IN(IN_MASK[f])
      ) u_prio (
        .clk(clk), .rst_n(rst_n), .hit_col(fn_hit[f]), .pad_in(pad_in),
        .win(fn_win[f]), .fn_in(fn_in[f])
      );

      AST_WIN_MATCHES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_win[f] != '0) |-> (fn_in[f] == |(fn_win[f] & pad_in))); // R6
    end
  endgenerate

endmodule

// File: tb/sim_pinmux_fabric.sv
module sim_pinmux_fabric;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [1:0] cfg_wdata = '0;
  logic [1:0] cfg_rdata;
  logic [3:0] fn_out = '0, fn_oe = '0, fn_in;
  logic [3:0] pad_in = '0, pad_out, pad_oe;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [3:0] M_OUT = 4'b1011;
  localparam logic [3:0] M_IN  = 4'b1101;
  localparam logic [3:0] M_BUS = 4'b1001;

  // {sel p3..p0, pad_in, fn_out, fn_oe, exp pad_out, exp pad_oe, exp fn_in}
  localparam logic [31:0] VEC [4] = '{
    32'h00AF1B38, 32'h1BE88FF0, 32'h1B188FF8, 32'h6CFFF111
  };

  always #5 clk = ~clk;

  pinmux_fabric u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fn_out(fn_out),
    .fn_oe(fn_oe), .fn_in(fn_in), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe)
  );

  // slot wiring written out per pad; 4 = empty
  function automatic int slot_fn(int pad, int slot);
    case (pad)
      0: return slot;
      1: return slot + 1;
      2: case (slot) 0: return 2; 1: return 3; 2: return 4; default: return 0; endcase
      default: case (slot) 0: return 3; 1: return 4; 2: return 0; default: return 1; endcase
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_sel(logic [7:0] s);
    for (int p = 0; p < 4; p++) wr(p, s[p*2 +: 2]);
  endtask

  task automatic model_check(logic [7:0] s, logic [3:0] pi, logic [3:0] fo, logic [3:0] fe);
    logic [3:0] e_out, e_oe, e_in;
    @(negedge clk);
    pad_in = pi; fn_out = fo; fn_oe = fe;
    #2;
    e_out = '0; e_oe = '0; e_in = '0;
    for (int p = 0; p < 4; p++) begin
      int t;
      t = slot_fn(p, int'(s[p*2 +: 2]));
      if (t < 4 && M_OUT[t]) begin
        e_out[p] = fo[t];
        e_oe[p]  = M_BUS[t] ? fe[t] : 1'b1;
      end
    end
    for (int f = 0; f < 4; f++) begin
      for (int p = 3; p >= 0; p--) begin
        if (slot_fn(p, int'(s[p*2 +: 2])) == f) e_in[f] = pi[p];
      end
      if (!M_IN[f]) e_in[f] = 1'b0;
    end
    check(pad_out == e_out, "R4 R3 pad_out", pad_out, e_out);
    check(pad_oe == e_oe, "R5 R3 pad_oe", pad_oe, e_oe);
    check(fn_in == e_in, "R6 R3 fn_in", fn_in, e_in);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state of every register
    for (int a = 0; a < 4; a++) begin
      @(negedge clk); cfg_addr = 3'(a); #1;
      check(cfg_rdata == 2'd0, "R1 reset value", {2'b0, cfg_rdata}, 4'd0);
    end
    // R1: write then read back
    wr(2, 2'd3);
    cfg_addr = 3'd2; #1;
    check(cfg_rdata == 2'd3, "R1 readback", {2'b0, cfg_rdata}, 4'd3);
    // R2: out-of-range writes are dropped, reads give 0
    for (int a = 4; a < 8; a++) wr(a, 2'd1);
    for (int a = 0; a < 8; a++) begin
      logic [1:0] e;
      e = (a == 2) ? 2'd3 : 2'd0;
      @(negedge clk); cfg_addr = 3'(a); #1;
      check(cfg_rdata == e, "R2 stray address", {2'b0, cfg_rdata}, {2'b0, e});
    end

    // table of directed vectors
    for (int i = 0; i < 4; i++) begin
      logic [31:0] v;
      v = VEC[i];
      load_sel(v[31:24]);
      @(negedge clk);
      pad_in = v[23:20]; fn_out = v[19:16]; fn_oe = v[15:12];
      #2;
      check(pad_out == v[11:8], "R4 R8 table pad_out", pad_out, v[11:8]);
      check(pad_oe == v[7:4], "R5 R8 table pad_oe", pad_oe, v[7:4]);
      check(fn_in == v[3:0], "R6 table fn_in", fn_in, v[3:0]);
    end

    // R7: every pad selecting the output-only function, all pads high
    load_sel(8'b00_11_00_01); // p0 s1, p1 s0, p2 s3->f0, p3 s0->f3
    load_sel(8'b11_10_00_01); // p0 s1, p1 s0, p3 s3 -> all f1 except p2
    @(negedge clk); pad_in = 4'hF; #2;
    check(fn_in[1] == 1'b0, "R7 output-only input", {3'b0, fn_in[1]}, 4'd0);
    // R8: function 1 on three pads carries its value everywhere
    @(negedge clk); fn_out = 4'b0010; fn_oe = 4'b0000; #2;
    check(pad_out == 4'b1011, "R8 fan-out value", pad_out, 4'b1011);

    // exhaustive sweep of all select combinations
    for (int c = 0; c < 256; c++) begin
      load_sel(8'(c));
      model_check(8'(c), 4'(c) ^ 4'hA, 4'(c >> 4) ^ 4'h5, 4'(c));
      model_check(8'(c), ~4'(c >> 2), 4'(c), ~4'(c >> 4));
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule